// File: doc/BRIEF.md
# Video Memory Indirect Access Port

This block puts video memory behind a small register window. The CPU never addresses that memory directly. It loads a pointer, then moves words through a single data register. A signed step register sets how far the pointer moves after every data store. One store sequence can therefore walk forward, walk backward, or stride through memory without reloading the pointer.

Reads never move the pointer. The attached RAM is synchronous, so a memory read finishes one clock after it is issued. A ready flag then rises, and the returned word stays on the output until the CPU starts its next access. The step value is cleared at reset, so until the CPU writes it, repeated stores land on the same word.

Top module: `vram_port`

## Requirements
- R1: After reset the pointer is 0, the step is 0 and `rd_valid_o` is low.
- R2: A write with `reg_sel_i` = 0 loads the pointer from `wdata_i`. The pointer appears on `mem_addr_o` after that edge. A data store issued in the very next cycle goes to the new pointer.
- R3: A read with `reg_sel_i` = 0 or 1 returns the memory word at the pointer. Such a read never changes the pointer.
- R4: A write with `reg_sel_i` = 1 raises `mem_we_o` in the same cycle. In that cycle `mem_addr_o` is the current pointer and `mem_wdata_o` equals `wdata_i`.
- R5: After each data store the pointer becomes pointer plus step, wrapping modulo 2^16. The step is two's complement: 16'hFFFF moves the pointer back by one.
- R6: A read with `reg_sel_i` = 2 returns the step value. It becomes valid one edge after the read.
- R7: A memory read issued in cycle N drives `rd_valid_o` low after edge N. After edge N+1, `rd_valid_o` is high and the word is on `rdata_o`. Both hold until the next read or write.
- R8: `reg_sel_i` = 3 selects nothing. A write there changes neither the pointer nor the step and leaves `mem_we_o` low. A read there returns 0 with valid one edge later.
- R9: When `rd_i` and `wr_i` are high together, the write is performed and the read is dropped. The write clears `rd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register index: 0 pointer, 1 data, 2 step, 3 unused |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 16 | CPU write data |
| rdata_o | output | 16 | Read result, held until next access |
| rd_valid_o | output | 1 | Read result ready |
| mem_addr_o | output | 16 | Video memory address (current pointer) |
| mem_wdata_o | output | 16 | Video memory write data |
| mem_we_o | output | 1 | Video memory write enable |
| mem_rdata_i | input | 16 | Video memory read data, one cycle after address |

## Verification
The assertions take three things for granted about the inputs:
- `mem_rdata_i` carries, one cycle later, the word at the address driven in the previous cycle.
- Strobes last a single cycle.
- The CPU does not start a new access while it still expects the word from an earlier read.

The bench keeps to these assumptions in three ways. It drives a registered RAM model, pulses each strobe for one cycle, and waits for `rd_valid_o` before issuing the next access. The one exception is the deliberate read-plus-write collision, which exercises R9.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STEP = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wr_ptr;
    logic wr_data;
    logic wr_step;
    logic rd_mem;
    logic rd_step;
    logic rd_none;
    logic acc;
  } op_t;

endpackage

// File: rtl/vram_port_decode.sv
module vram_port_decode
  import vram_port_pkg::*;
(
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output op_t              op_o
);

  reg_sel_e sel;
  logic     rd_eff;

  assign sel    = reg_sel_e'(reg_sel_i);
  assign rd_eff = rd_i & ~wr_i;  // write wins a collision

  always_comb begin
    op_o         = '0;
    op_o.acc     = rd_i | wr_i;
    op_o.wr_ptr  = wr_i && (sel == SEL_PTR);
    op_o.wr_data = wr_i && (sel == SEL_DATA);
    op_o.wr_step = wr_i && (sel == SEL_STEP);
    op_o.rd_mem  = rd_eff && ((sel == SEL_PTR) || (sel == SEL_DATA));
    op_o.rd_step = rd_eff && (sel == SEL_STEP);
    op_o.rd_none = rd_eff && (sel == SEL_NONE);
  end

endmodule

// File: rtl/vram_port_ptr.sv
module vram_port_ptr
  import vram_port_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_t           op_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] step_o
);

  logic [AW-1:0] ptr_q, step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      step_q <= '0;
    end else begin
      if (op_i.wr_ptr)       ptr_q <= wdata_i[AW-1:0];
      else if (op_i.wr_data) ptr_q <= ptr_q + step_q;  // wraps at 2^AW
      if (op_i.wr_step)      step_q <= wdata_i[AW-1:0];
    end
  end

  assign ptr_o  = ptr_q;
  assign step_o = step_q;

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.wr_data |=> ptr_q == AW'($past(ptr_q) + $past(step_q)));  // R5

  AST_PTR_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_i.wr_ptr && !op_i.wr_data |=> $stable(ptr_q));  // R3

  AST_STEP_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_i.wr_step |=> $stable(step_q));  // R8

endmodule

// File: rtl/vram_port_ret.sv
module vram_port_ret
  import vram_port_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_t           op_i,
  input  logic [AW-1:0] step_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_valid_o
);

  logic [DW-1:0] rdata_q, step_ext;
  logic          valid_q, pend_q;

  assign step_ext = DW'(signed'(step_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (op_i.acc) begin
      valid_q <= 1'b0;
      pend_q  <= op_i.rd_mem;
      if (op_i.rd_step) begin
        rdata_q <= step_ext;
        valid_q <= 1'b1;
      end else if (op_i.rd_none) begin
        rdata_q <= '0;
        valid_q <= 1'b1;
      end
    end else if (pend_q) begin
      rdata_q <= mem_rdata_i;
      valid_q <= 1'b1;
      pend_q  <= 1'b0;
    end
  end

  assign rdata_o    = rdata_q;
  assign rd_valid_o = valid_q;

  AST_MEM_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.rd_mem |=> !rd_valid_o);  // R7

  AST_MEM_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !op_i.acc |=> rd_valid_o && rdata_o == $past(mem_rdata_i));  // R3

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !op_i.acc |=> rd_valid_o && $stable(rdata_o));  // R7

  AST_STEP_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.rd_step |=> rd_valid_o && rdata_o == DW'(signed'($past(step_i))));  // R6

  AST_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.acc && !op_i.rd_step && !op_i.rd_none |=> !rd_valid_o);  // R9

endmodule

// File: rtl/vram_port.sv
module vram_port
  import vram_port_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rd_valid_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             mem_we_o,
  input  logic [DW-1:0]    mem_rdata_i
);

  op_t           op;
  logic [AW-1:0] ptr, step;

  vram_port_decode u_decode (
    .reg_sel_i (reg_sel_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .op_o      (op)
  );

  vram_port_ptr #(.AW(AW), .DW(DW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .wdata_i (wdata_i),
    .ptr_o   (ptr),
    .step_o  (step)
  );

  vram_port_ret #(.AW(AW), .DW(DW)) u_ret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .step_i      (step),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rdata_o),
    .rd_valid_o  (rd_valid_o)
  );

  assign mem_addr_o  = ptr;
  assign mem_wdata_o = wdata_i;
  assign mem_we_o    = op.wr_data;

  AST_STORE_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> mem_addr_o == AW'($past(mem_addr_o) + $past(step)));  // R5

  AST_LOAD_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && reg_sel_i == SEL_PTR |=> mem_addr_o == $past(wdata_i[AW-1:0]));  // R2

endmodule

// File: tb/vram_port_test.sv
module vram_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, mem_addr, mem_wdata, mem_rdata;
  logic        rd_valid, mem_we;
  logic [15:0] ram [256];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  vram_port uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(reg_sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  function automatic logic [15:0] pat(input int i);
    return 16'hA500 ^ 16'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] s, input bit is_mem,
                         output logic [15:0] d);
    @(negedge clk);
    reg_sel = s; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    if (is_mem) begin
      chk(!rd_valid, "R7 not ready after one edge", 16'(rd_valid), 16'h0);
      @(negedge clk);
    end
    chk(rd_valid, "R7 ready", 16'(rd_valid), 16'h1);
    d = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk(mem_addr == 16'h0, "R1 pointer", mem_addr, 16'h0);
    chk(!rd_valid, "R1 valid low", 16'(rd_valid), 16'h0);
    do_read(2'd2, 1'b0, d);
    chk(d == 16'h0, "R1 step zero", d, 16'h0);
  endtask

  task automatic t_load_read();
    logic [15:0] d;
    do_write(2'd0, 16'h0040);
    chk(mem_addr == 16'h0040, "R2 pointer loaded", mem_addr, 16'h0040);
    do_read(2'd1, 1'b1, d);
    chk(d == pat(16'h40), "R3 data read", d, pat(16'h40));
    do_read(2'd0, 1'b1, d);
    chk(d == pat(16'h40), "R3 pointer-register read", d, pat(16'h40));
    chk(mem_addr == 16'h0040, "R3 pointer unchanged", mem_addr, 16'h0040);
  endtask

  task automatic t_store_step();
    logic [15:0] d;
    do_write(2'd2, 16'h0002);
    @(negedge clk);
    reg_sel = 2'd1; wdata = 16'h1111; wr = 1'b1;
    #1;
    chk(mem_we, "R4 write enable", 16'(mem_we), 16'h1);
    chk(mem_addr == 16'h0040, "R4 store address", mem_addr, 16'h0040);
    chk(mem_wdata == 16'h1111, "R4 store data", mem_wdata, 16'h1111);
    @(negedge clk);
    wr = 1'b0;
    chk(mem_addr == 16'h0042, "R5 step +2", mem_addr, 16'h0042);
    do_write(2'd1, 16'h2222);
    chk(mem_addr == 16'h0044, "R5 step +2 again", mem_addr, 16'h0044);
    do_write(2'd0, 16'h0040);
    do_read(2'd1, 1'b1, d);
    chk(d == 16'h1111, "R4 stored word", d, 16'h1111);
    do_write(2'd0, 16'h0042);
    do_read(2'd1, 1'b1, d);
    chk(d == 16'h2222, "R4 second stored word", d, 16'h2222);
  endtask

  task automatic t_negative();
    logic [15:0] d;
    do_write(2'd2, 16'hFFFF);
    do_read(2'd2, 1'b0, d);
    chk(d == 16'hFFFF, "R6 step read back", d, 16'hFFFF);
    do_write(2'd0, 16'h0001);
    do_write(2'd1, 16'h3333);
    chk(mem_addr == 16'h0000, "R5 step -1", mem_addr, 16'h0000);
    do_write(2'd1, 16'h4444);
    chk(mem_addr == 16'hFFFF, "R5 wrap below zero", mem_addr, 16'hFFFF);
    do_write(2'd2, 16'h0000);
    do_write(2'd1, 16'h5555);
    chk(mem_addr == 16'hFFFF, "R5 zero step holds", mem_addr, 16'hFFFF);
    do_write(2'd2, 16'h0010);
    do_write(2'd0, 16'hFFF8);
    do_write(2'd1, 16'h6666);
    chk(mem_addr == 16'h0008, "R5 wrap above top", mem_addr, 16'h0008);
  endtask

  task automatic t_back_to_back();
    logic [15:0] d;
    @(negedge clk);
    reg_sel = 2'd0; wdata = 16'h0080; wr = 1'b1;
    @(negedge clk);
    reg_sel = 2'd1; wdata = 16'h7777;
    #1;
    chk(mem_addr == 16'h0080, "R2 next-cycle store address", mem_addr, 16'h0080);
    @(negedge clk);
    wr = 1'b0;
    do_write(2'd0, 16'h0080);
    do_read(2'd1, 1'b1, d);
    chk(d == 16'h7777, "R2 next-cycle store landed", d, 16'h7777);
  endtask

  task automatic t_hold();
    logic [15:0] d;
    do_write(2'd0, 16'h0033);
    do_read(2'd1, 1'b1, d);
    repeat (5) @(negedge clk);
    chk(rd_valid && rdata == pat(16'h33), "R7 result held", rdata, pat(16'h33));
    do_write(2'd2, 16'h0001);
    chk(!rd_valid, "R7 cleared by access", 16'(rd_valid), 16'h0);
  endtask

  task automatic t_unused();
    logic [15:0] d;
    do_write(2'd0, 16'h0050);
    do_write(2'd2, 16'h0003);
    @(negedge clk);
    reg_sel = 2'd3; wdata = 16'h1234; wr = 1'b1;
    #1;
    chk(!mem_we, "R8 no store", 16'(mem_we), 16'h0);
    @(negedge clk);
    wr = 1'b0;
    chk(mem_addr == 16'h0050, "R8 pointer kept", mem_addr, 16'h0050);
    do_read(2'd2, 1'b0, d);
    chk(d == 16'h0003, "R8 step kept", d, 16'h0003);
    do_read(2'd3, 1'b0, d);
    chk(d == 16'h0000, "R8 unused reads zero", d, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    do_write(2'd0, 16'h0060);
    do_read(2'd2, 1'b0, d);
    @(negedge clk);
    reg_sel = 2'd1; wdata = 16'h9999; wr = 1'b1; rd = 1'b1;
    #1;
    chk(mem_we, "R9 write performed", 16'(mem_we), 16'h1);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk(!rd_valid, "R9 read dropped", 16'(rd_valid), 16'h0);
    @(negedge clk);
    chk(!rd_valid, "R9 no late result", 16'(rd_valid), 16'h0);
    chk(mem_addr == 16'h0063, "R9 pointer stepped", mem_addr, 16'h0063);
    do_write(2'd0, 16'h0060);
    do_read(2'd1, 1'b1, d);
    chk(d == 16'h9999, "R9 word stored", d, 16'h9999);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_read();
    t_store_step();
    t_negative();
    t_back_to_back();
    t_hold();
    t_unused();
    t_collision();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %h expected %h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule